// File: doc/BRIEF.md
# Selectable Pseudo-Random Bit-Error-Rate Tester

This block tests a multi-gigabit serial link with known data. Its transmit side produces one of eight pseudo-random bit sequences as parallel words, one word per clock, for a serialiser. Its receive side takes the deserialised words, trains its own copy of the sequence from the incoming bits, and counts mismatched bits once it has locked. It also counts the frames it has sent. The test uses a fixed frame of a set number of words.

Software uses a small register window. One register holds the run enable and the pattern choice. A command register carries one-cycle actions: counter clear, snapshot and single-bit error injection. Four read registers return the snapshot of the 48-bit frame and bit-error counters, split into low and high words. The snapshot latches both counters on the same edge, so the pair always matches.

Top module: `prbs_bert_top`

## Requirements
- R1: Pattern select value p (0..7) picks the sequence with recurrence b[n] = b[n-A] ^ b[n-B], where (A,B) is (7,6), (9,5), (11,9), (15,14), (20,3), (23,18), (29,27) or (31,28) for p = 0..7. Each `tx_word` holds 20 consecutive sequence bits, with the oldest bit in bit 19.
- R2: On reset, and whenever the pattern select changes, the generator state is loaded with all ones, and nothing is produced on that edge. The first word after the restart is built from that all-ones history.
- R3: The checker sets lock only after 64 consecutive error-free words have been compared against a prediction trained on received bits. While lock is low, the checker keeps retraining its prediction from the received bits. Lock is read at bit 8 of register 0.
- R4: Once locked, the checker predicts from its own state. It drops lock after 8 consecutive words with errors. Seven bad words, or any run of bad words broken by a clean word, keep lock. A pattern change also drops lock.
- R5: While locked, each received word adds the number of mismatched bits to the bit-error counter. Words received while unlocked add nothing.
- R6: The frame counter adds one for every 256 words transmitted while running (the count is the FRAME_WORDS parameter).
- R7: Both counters stop at all ones and do not wrap.
- R8: Writing 1 to bit 0 of register 1 clears both counters and the partial-frame word count.
- R9: Writing 1 to bit 1 of register 1 copies both counters into the read registers on the same edge. Registers 2/3 return frames (low 32 bits / high bits) and registers 4/5 return bit errors. They do not change until the next snapshot.
- R10: Writing 1 to bit 2 of register 1 inverts bit 0 of the next transmitted word only.
- R11: Register 0 bit 0 is run and bits 3:1 are the pattern select. With run low, `tx_word`, the checker and both counters hold.
- R12: After reset, `tx_word` is zero, register 0 reads zero and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for transmit, receive and registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| tx_word | output | WORD_W | Parallel word to the serialiser |
| rx_word | input | WORD_W | Parallel word from the deserialiser |

## Verification
The properties assume that received words arrive on every running clock, aligned to the same word boundary as the transmit side. They also assume that a clear is never requested while a count is expected to grow. The bench loops `tx_word` back to `rx_word` through an XOR mask, so every error it adds falls on a known word and bit. It changes the pattern only while run is low when it checks sequence contents. It checks counter growth through snapshots taken after the link is quiet, so that no clear and no count meet on the same edge.

// File: rtl/prbs_bert_pkg.sv
package prbs_bert_pkg;

  localparam int LFSR_W = 31;
  localparam int BUS_W  = 32;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_CMD    = 3'd1;
  localparam logic [2:0] A_FRM_LO = 3'd2;
  localparam logic [2:0] A_FRM_HI = 3'd3;
  localparam logic [2:0] A_ERR_LO = 3'd4;
  localparam logic [2:0] A_ERR_HI = 3'd5;

  typedef struct packed {
    logic [2:0] pat;
    logic       run;
  } ctrl_t;

  // Feedback bit for the selected polynomial; s[0] is the newest bit.
  function automatic logic lfsr_fb(input logic [LFSR_W-1:0] s, input logic [2:0] pat);
    logic b;
    case (pat)
      3'd0:    b = s[6]  ^ s[5];
      3'd1:    b = s[8]  ^ s[4];
      3'd2:    b = s[10] ^ s[8];
      3'd3:    b = s[14] ^ s[13];
      3'd4:    b = s[19] ^ s[2];
      3'd5:    b = s[22] ^ s[17];
      3'd6:    b = s[28] ^ s[26];
      default: b = s[30] ^ s[27];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_bert_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [2:0]        pat,
  input  logic              inject,
  output logic              strobe,
  output logic [WORD_W-1:0] tx_word
);

  logic [LFSR_W-1:0] st_q, st_d, walk;
  logic [2:0]        pat_q;
  logic [WORD_W-1:0] tx_q, tx_d, word;
  logic              reseed;

  always_comb begin
    reseed = (pat != pat_q);
    walk   = st_q;
    word   = '0;
    for (int i = 0; i < WORD_W; i++) begin
      word[WORD_W-1-i] = lfsr_fb(walk, pat);
      walk = {walk[LFSR_W-2:0], word[WORD_W-1-i]};
    end
    st_d = st_q;
    tx_d = tx_q;
    if (reseed) begin
      st_d = '1;
    end else if (en) begin
      st_d = walk;
      tx_d = word ^ WORD_W'(inject);
    end
  end

  assign strobe  = en & ~reseed;
  assign tx_word = tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '1;
      pat_q <= '0;
      tx_q  <= '0;
    end else begin
      st_q  <= st_d;
      pat_q <= pat;
      tx_q  <= tx_d;
    end
  end

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_bert_pkg::*;
#(
  parameter int WORD_W     = 20,
  parameter int LOCK_GOOD  = 64,
  parameter int UNLOCK_BAD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [2:0]        pat,
  input  logic [WORD_W-1:0] rx_word,
  output logic              locked,
  output logic              pat_chg,
  output logic [WORD_W-1:0] err_vec
);

  localparam int GOOD_W = $clog2(LOCK_GOOD + 1);
  localparam int BAD_W  = $clog2(UNLOCK_BAD + 1);

  logic [LFSR_W-1:0] st_q, st_d, walk, hist;
  logic [WORD_W-1:0] expect_w;
  logic [2:0]        pat_q;
  logic              lock_q, lock_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic [BAD_W-1:0]  bad_q, bad_d;
  logic              err_any;

  always_comb begin
    walk     = st_q;
    hist     = st_q;
    expect_w = '0;
    for (int i = 0; i < WORD_W; i++) begin
      expect_w[WORD_W-1-i] = lfsr_fb(walk, pat);
      walk = {walk[LFSR_W-2:0], expect_w[WORD_W-1-i]};
      hist = {hist[LFSR_W-2:0], rx_word[WORD_W-1-i]};
    end
    pat_chg = (pat != pat_q);
    err_vec = (en && !pat_chg) ? (rx_word ^ expect_w) : '0;
    err_any = |err_vec;

    st_d   = st_q;
    lock_d = lock_q;
    good_d = good_q;
    bad_d  = bad_q;
    if (pat_chg) begin
      lock_d = 1'b0;
      good_d = '0;
      bad_d  = '0;
    end else if (en) begin
      st_d = lock_q ? walk : hist;
      if (!lock_q) begin
        if (err_any) begin
          good_d = '0;
        end else if (good_q == GOOD_W'(LOCK_GOOD - 1)) begin
          lock_d = 1'b1;
          good_d = '0;
        end else begin
          good_d = good_q + 1'b1;
        end
      end else begin
        if (!err_any) begin
          bad_d = '0;
        end else if (bad_q == BAD_W'(UNLOCK_BAD - 1)) begin
          lock_d = 1'b0;
          bad_d  = '0;
        end else begin
          bad_d = bad_q + 1'b1;
        end
      end
    end
  end

  assign locked = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '1;
      pat_q  <= '0;
      lock_q <= 1'b0;
      good_q <= '0;
      bad_q  <= '0;
    end else begin
      st_q   <= st_d;
      pat_q  <= pat;
      lock_q <= lock_d;
      good_q <= good_d;
      bad_q  <= bad_d;
    end
  end

endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int W     = 48,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [INC_W-1:0] add,
  output logic [W-1:0]     cnt
);

  logic [W:0]   sum;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    sum   = {1'b0, cnt_q} + {{(W + 1 - INC_W){1'b0}}, add};
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (add_en) cnt_d = sum[W] ? {W{1'b1}} : sum[W-1:0];
  end

  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bert_regs.sv
module bert_regs
  import prbs_bert_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             locked,
  input  logic             word_strobe,
  input  logic [CNT_W-1:0] frame_cnt,
  input  logic [CNT_W-1:0] err_cnt,
  output ctrl_t            ctrl,
  output logic             clr,
  output logic             inject
);

  ctrl_t            ctrl_q, ctrl_d;
  logic             inj_q, inj_d;
  logic [CNT_W-1:0] snap_fr_q, snap_fr_d, snap_er_q, snap_er_d;
  logic             wr_ctrl, wr_cmd, snap;
  logic [63:0]      fr_w, er_w;
  logic             unused_wdata;

  assign wr_ctrl      = bus_wr && (bus_addr == A_CTRL);
  assign wr_cmd       = bus_wr && (bus_addr == A_CMD);
  assign clr          = wr_cmd & bus_wdata[0];
  assign snap         = wr_cmd & bus_wdata[1];
  assign unused_wdata = ^bus_wdata[BUS_W-1:4];

  always_comb begin
    ctrl_d    = wr_ctrl ? ctrl_t'(bus_wdata[3:0]) : ctrl_q;
    inj_d     = (wr_cmd & bus_wdata[2]) | (inj_q & ~word_strobe);
    snap_fr_d = snap ? frame_cnt : snap_fr_q;
    snap_er_d = snap ? err_cnt : snap_er_q;
  end

  assign fr_w = 64'(snap_fr_q);
  assign er_w = 64'(snap_er_q);

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = {23'd0, locked, 4'd0, ctrl_q};
      A_FRM_LO: bus_rdata = fr_w[31:0];
      A_FRM_HI: bus_rdata = fr_w[63:32];
      A_ERR_LO: bus_rdata = er_w[31:0];
      A_ERR_HI: bus_rdata = er_w[63:32];
      default:  bus_rdata = '0;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign inject = inj_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      inj_q     <= 1'b0;
      snap_fr_q <= '0;
      snap_er_q <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      inj_q     <= inj_d;
      snap_fr_q <= snap_fr_d;
      snap_er_q <= snap_er_d;
    end
  end

endmodule

// File: rtl/prbs_bert_top.sv
module prbs_bert_top
  import prbs_bert_pkg::*;
#(
  parameter int WORD_W      = 20,
  parameter int CNT_W       = 48,
  parameter int FRAME_WORDS = 256,
  parameter int LOCK_GOOD   = 64,
  parameter int UNLOCK_BAD  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [WORD_W-1:0] tx_word,
  input  logic [WORD_W-1:0] rx_word
);

  localparam int FW_W  = $clog2(FRAME_WORDS);
  localparam int POP_W = $clog2(WORD_W + 1);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  ctrl_t             ctrl;
  logic              cnt_clr, inject, word_strobe, frame_done;
  logic              chk_locked, chk_pat_chg, chk_err_any;
  logic [WORD_W-1:0] err_vec;
  logic [POP_W-1:0]  err_pop;
  logic [FW_W-1:0]   wc_q, wc_d;
  logic [CNT_W-1:0]  frame_cnt, err_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  bert_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .locked(chk_locked),
    .word_strobe(word_strobe), .frame_cnt(frame_cnt), .err_cnt(err_cnt),
    .ctrl(ctrl), .clr(cnt_clr), .inject(inject)
  );

  prbs_gen #(.WORD_W(WORD_W)) u_gen (
    .clk(clk), .rst_n(rst_sync_n), .en(ctrl.run), .pat(ctrl.pat),
    .inject(inject), .strobe(word_strobe), .tx_word(tx_word)
  );

  prbs_chk #(.WORD_W(WORD_W), .LOCK_GOOD(LOCK_GOOD), .UNLOCK_BAD(UNLOCK_BAD)) u_chk (
    .clk(clk), .rst_n(rst_sync_n), .en(ctrl.run), .pat(ctrl.pat),
    .rx_word(rx_word), .locked(chk_locked), .pat_chg(chk_pat_chg), .err_vec(err_vec)
  );

  always_comb begin
    err_pop = '0;
    for (int i = 0; i < WORD_W; i++) err_pop = err_pop + POP_W'(err_vec[i]);
  end
  assign chk_err_any = |err_vec;

  // Word position inside the current frame
  always_comb begin
    wc_d       = wc_q;
    frame_done = 1'b0;
    if (cnt_clr) begin
      wc_d = '0;
    end else if (word_strobe) begin
      if (wc_q == FW_W'(FRAME_WORDS - 1)) begin
        wc_d       = '0;
        frame_done = 1'b1;
      end else begin
        wc_d = wc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wc_q <= '0;
    else             wc_q <= wc_d;
  end

  sat_cnt #(.W(CNT_W), .INC_W(1)) u_frames (
    .clk(clk), .rst_n(rst_sync_n), .clr(cnt_clr), .add_en(frame_done),
    .add(1'b1), .cnt(frame_cnt)
  );

  sat_cnt #(.W(CNT_W), .INC_W(POP_W)) u_errors (
    .clk(clk), .rst_n(rst_sync_n), .clr(cnt_clr), .add_en(chk_locked),
    .add(err_pop), .cnt(err_cnt)
  );

endmodule

// File: rtl/bert_sva.sv
module bert_sva #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             locked,
  input logic             err_any,
  input logic             pat_chg,
  input logic [CNT_W-1:0] frame_cnt,
  input logic [CNT_W-1:0] err_cnt
);

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (frame_cnt == '0 && err_cnt == '0));

  // R5
  err_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !clr) |=> $stable(err_cnt));

  // R6
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (frame_cnt == $past(frame_cnt) || frame_cnt == $past(frame_cnt) + 1'b1));

  // R7
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == {CNT_W{1'b1}} && !clr) |=> err_cnt == {CNT_W{1'b1}});

  // R4
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !err_any && !pat_chg) |=> locked);

  // R3
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !$past(err_any));

endmodule

bind prbs_bert_top bert_sva #(.CNT_W(CNT_W)) u_bert_sva (
  .clk(clk), .rst_n(rst_sync_n), .clr(cnt_clr), .locked(chk_locked),
  .err_any(chk_err_any), .pat_chg(chk_pat_chg), .frame_cnt(frame_cnt),
  .err_cnt(err_cnt)
);

// File: tb/tb_prbs_bert_top.sv
module tb_prbs_bert_top;

  localparam int CLK_P = 10;
  localparam int WW    = 20;
  localparam int CW    = 8;
  localparam int FW    = 16;

  logic          clk;
  logic          rst_n;
  logic          bus_wr;
  logic [2:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [WW-1:0] tx_word;
  logic [WW-1:0] rx_word;
  logic [WW-1:0] flip;

  int n_chk;
  int n_fail;
  int cur_pat;
  logic [30:0] m_st;

  assign rx_word = tx_word ^ flip;

  prbs_bert_top #(.WORD_W(WW), .CNT_W(CW), .FRAME_WORDS(FW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_word(tx_word), .rx_word(rx_word)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic snap(output longint fr, output longint er);
    logic [31:0] v;
    wr(3'd1, 32'd2);
    rd(3'd2, v); fr = longint'(v);
    rd(3'd4, v); er = longint'(v);
  endtask

  task automatic set_ctrl(input int p, input bit run);
    cur_pat = p;
    wr(3'd0, 32'((p << 1) | int'(run)));
  endtask

  task automatic run_words(input int k);
    set_ctrl(cur_pat, 1'b1);
    repeat (k - 1) @(posedge clk);
    set_ctrl(cur_pat, 1'b0);
  endtask

  task automatic flip_words(input logic [WW-1:0] m, input int k);
    @(negedge clk);
    flip = m;
    repeat (k) @(posedge clk);
    @(negedge clk);
    flip = '0;
  endtask

  task automatic lock_bit(output bit l);
    logic [31:0] v;
    rd(3'd0, v);
    l = v[8];
  endtask

  // Next 20 bits of the sequence for pattern p, oldest bit in bit 19
  task automatic model_word(input int p, output logic [WW-1:0] w);
    int a, b;
    logic nb;
    case (p)
      0: begin a = 7;  b = 6;  end
      1: begin a = 9;  b = 5;  end
      2: begin a = 11; b = 9;  end
      3: begin a = 15; b = 14; end
      4: begin a = 20; b = 3;  end
      5: begin a = 23; b = 18; end
      6: begin a = 29; b = 27; end
      default: begin a = 31; b = 28; end
    endcase
    for (int i = 0; i < WW; i++) begin
      nb = m_st[a-1] ^ m_st[b-1];
      w[WW-1-i] = nb;
      m_st = {m_st[29:0], nb};
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0]   v;
    logic [WW-1:0] w, got, first_bad_got, first_bad_exp;
    longint        fr, er, fr2, er2;
    bit            ok, l;

    n_chk = 0; n_fail = 0; cur_pat = 0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; flip = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R12 reset state
    @(negedge clk);
    check(tx_word == '0, "R12 tx_word", longint'(tx_word), 0);
    rd(3'd0, v);
    check(v == 32'd0, "R12 ctrl reg", longint'(v), 0);
    snap(fr, er);
    check(fr == 0 && er == 0, "R12 counters", fr + er, 0);

    // R1 R2 R3 sweep all patterns
    for (int p = 0; p < 8; p++) begin
      set_ctrl(p, 1'b0);
      repeat (3) @(posedge clk);
      m_st = '1;
      set_ctrl(p, 1'b1);
      ok = 1'b1; first_bad_got = '0; first_bad_exp = '0;
      for (int k = 0; k < 40; k++) begin
        @(posedge clk);
        @(negedge clk);
        got = tx_word;
        model_word(p, w);
        if (got !== w && ok) begin
          ok = 1'b0; first_bad_got = got; first_bad_exp = w;
        end
      end
      check(ok, $sformatf("R1 R2 sequence pattern %0d", p), longint'(first_bad_got), longint'(first_bad_exp));
      repeat (120) @(posedge clk);
      lock_bit(l);
      check(l, $sformatf("R3 lock on clean link pattern %0d", p), longint'(l), 1);
      set_ctrl(p, 1'b0);
    end

    // R6 frames, R8 clear of partial frame, R9 snapshot holding
    wr(3'd1, 32'd1);
    run_words(87);
    snap(fr, er);
    check(fr == 5, "R6 frames after 87 words", fr, 5);
    check(er == 0, "R5 clean loopback errors", er, 0);
    wr(3'd1, 32'd1);
    run_words(9);
    snap(fr, er);
    check(fr == 0, "R8 frames after clear", fr, 0);
    run_words(7);
    snap(fr, er);
    check(fr == 1, "R8 partial frame restarted", fr, 1);
    run_words(40);
    rd(3'd2, v);
    check(v == 32'd1, "R9 read without snapshot", longint'(v), 1);
    snap(fr, er);
    check(fr == 3, "R9 new snapshot", fr, 3);

    // R3 lock needs 64 clean words
    set_ctrl(0, 1'b0);
    wr(3'd1, 32'd1);
    flip = 20'h1;
    set_ctrl(0, 1'b1);
    repeat (100) @(posedge clk);
    lock_bit(l);
    check(!l, "R3 no lock while errored", longint'(l), 0);
    @(negedge clk);
    flip = '0;
    repeat (61) @(posedge clk);
    lock_bit(l);
    check(!l, "R3 not yet locked after 60 clean", longint'(l), 0);
    repeat (10) @(posedge clk);
    lock_bit(l);
    check(l, "R3 locked after 70 clean", longint'(l), 1);

    // R4 R5 unlock threshold and counting
    flip_words(20'h1, 7);
    lock_bit(l);
    check(l, "R4 lock kept after 7 bad", longint'(l), 1);
    snap(fr, er);
    check(er == 7, "R5 errors after 7 bad", er, 7);
    flip_words(20'h1, 8);
    lock_bit(l);
    check(!l, "R4 lock lost after 8 bad", longint'(l), 0);
    snap(fr, er);
    check(er == 15, "R5 errors after 8 more", er, 15);
    flip_words(20'h1, 5);
    snap(fr, er);
    check(er == 15, "R5 no count while unlocked", er, 15);
    repeat (150) @(posedge clk);
    lock_bit(l);
    check(l, "R3 relock", longint'(l), 1);

    // R8 clear of errors
    wr(3'd1, 32'd1);
    snap(fr, er);
    check(er == 0 && fr == 0, "R8 counters cleared", er + fr, 0);

    // R10 single bit inject
    wr(3'd1, 32'd4);
    repeat (5) @(posedge clk);
    snap(fr, er);
    check(er == 1, "R10 one injected error", er, 1);

    // R11 pattern change drops lock
    set_ctrl(1, 1'b1);
    @(posedge clk);
    lock_bit(l);
    check(!l, "R11 pattern change unlocks", longint'(l), 0);
    repeat (150) @(posedge clk);
    lock_bit(l);
    check(l, "R3 lock on new pattern", longint'(l), 1);

    // R7 error counter saturation, 14 words of 20 errors
    wr(3'd1, 32'd1);
    for (int k = 0; k < 14; k++) flip_words('1, 1);
    snap(fr, er);
    check(er == 255, "R7 error saturation", er, 255);
    lock_bit(l);
    check(l, "R4 alternating bad words keep lock", longint'(l), 1);

    // R11 hold while stopped
    set_ctrl(1, 1'b0);
    @(negedge clk);
    got = tx_word;
    snap(fr, er);
    repeat (10) @(posedge clk);
    snap(fr2, er2);
    @(negedge clk);
    check(tx_word == got, "R11 tx_word held", longint'(tx_word), longint'(got));
    check(fr2 == fr && er2 == er, "R11 counters held", fr2 + er2, fr + er);

    // R7 frame counter saturation
    wr(3'd1, 32'd1);
    run_words(4200);
    snap(fr, er);
    check(fr == 255, "R7 frame saturation", fr, 255);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule